// File: doc/BRIEF.md
# Reference Clock Ratio Auto-Detector

This block finds out which of three reference frequency families is wired to a clock-recovery loop and picks the matching VCO-to-reference multiply ratio. The choices are x16, x32 and x128, chosen so that ratio times reference lands in the 2.5 to 2.7 GHz VCO window. No strap pin is needed. The block counts rising edges of the reference over a fixed window of a free-running measurement clock. It compares the count against three programmable bands, and guard gaps separate the bands.

Measurement never stops. A new band becomes the selection only after two back-to-back windows agree on it. A count that falls between or outside the bands drops the valid flag but keeps the last ratio. A window with no reference edges at all clears the reference-present flag as well, so the calibration sequencer knows the reference has gone. The measurement clock must run faster than twice the highest reference frequency, because the reference is sampled by a synchronizer.

Top module: `ref_ratio_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ratio_code` is 0, `ratio_valid` is 0 and `ref_present` is 0.
- R2: The three outputs change only at the end of a measurement window, once every `WINDOW` measurement-clock cycles counted from reset release.
- R3: Ratio encoding: code 0 selects x16 (count in band 0, default 270..370), code 1 selects x32 (band 1, default 130..190), and code 2 selects x128 (band 2, default 30..55). Code 3 never appears.
- R4: A single window whose count falls in a band different from the previous window's changes neither `ratio_code` nor `ratio_valid`.
- R5: A window with zero reference edges clears `ref_present` and `ratio_valid` and leaves `ratio_code` unchanged.
- R6: A non-zero count outside all bands clears `ratio_valid`, keeps `ratio_code`, and keeps `ref_present` at 1.
- R7: Any window with at least one reference edge sets `ref_present`.
- R8: When two consecutive windows fall in the same band, that band's code is committed and `ratio_valid` is set. A move of the reference to another band therefore re-selects the ratio without a reset.
- R9: `ratio_valid` high implies `ref_present` high, and `ratio_code` changes only on a commit, so `ratio_valid` is 1 after any change of `ratio_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock under measurement, asynchronous to `clk` |
| ratio_code | output | 2 | Selected multiply ratio (0: x16, 1: x32, 2: x128) |
| ratio_valid | output | 1 | The selected ratio matches the current reference |
| ref_present | output | 1 | Reference edges were seen in the last window |

## Verification
The hardest case to reach is the debounce: one whole window in a foreign band, followed by a return to the old band. The stimulus has to line up with the window boundaries, and those are not visible at the ports. The bench starts the reference from silence and treats the rise of `ref_present` as a known window end. From that point it counts cycles so that a burst of the fast reference fills exactly one window. It then checks that the ratio and the valid flag stay the same across that window and the one after it.

// File: rtl/refdet_pkg.sv
package refdet_pkg;
  typedef enum logic [1:0] {
    RATIO_X16  = 2'd0,
    RATIO_X32  = 2'd1,
    RATIO_X128 = 2'd2
  } ratio_e;

  localparam int NUM_BANDS = 3;

  typedef struct packed {
    logic   zero;
    logic   hit;
    ratio_e code;
  } verdict_t;
endpackage

// File: rtl/refdet_edge_sync.sv
module refdet_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk,
  output logic rise
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], ref_clk};
  end

  // rising edge seen after the synchronizer stages
  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
endmodule

// File: rtl/refdet_window.sv
module refdet_window #(
  parameter int WINDOW = 1024,
  parameter int CW     = $clog2(WINDOW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic          win_end,
  output logic [CW-1:0] count
);
  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [WW-1:0] wcnt;
  logic [CW-1:0] ecnt;
  logic [CW-1:0] ecnt_nxt;

  assign win_end  = (wcnt == WW'(WINDOW - 1));
  assign ecnt_nxt = (ecnt == CMAX) ? ecnt : ecnt + CW'(tick);
  assign count    = ecnt_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      ecnt <= '0;
    end else if (win_end) begin
      wcnt <= '0;
      ecnt <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
      ecnt <= ecnt_nxt;
    end
  end
endmodule

// File: rtl/refdet_classify.sv
module refdet_classify
  import refdet_pkg::*;
#(
  parameter int CW = 11,
  parameter int BAND_LO [NUM_BANDS] = '{270, 130, 30},
  parameter int BAND_HI [NUM_BANDS] = '{370, 190, 55}
) (
  input  logic [CW-1:0] count,
  output verdict_t      verdict
);
  logic [NUM_BANDS-1:0] hit_v;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign hit_v[b] = (count >= CW'(BAND_LO[b])) && (count <= CW'(BAND_HI[b]));
  end

  always_comb begin
    verdict.zero = (count == '0);
    verdict.hit  = |hit_v;
    verdict.code = RATIO_X16;
    for (int b = NUM_BANDS - 1; b >= 0; b--) begin
      if (hit_v[b]) verdict.code = ratio_e'(2'(b));
    end
  end
endmodule

// File: rtl/refdet_decide.sv
module refdet_decide
  import refdet_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     win_end,
  input  verdict_t verdict,
  output ratio_e   ratio,
  output logic     valid,
  output logic     present
);
  ratio_e prev_code;
  logic   prev_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio     <= RATIO_X16;
      valid     <= 1'b0;
      present   <= 1'b0;
      prev_code <= RATIO_X16;
      prev_hit  <= 1'b0;
    end else if (win_end) begin
      prev_hit  <= verdict.hit;
      prev_code <= verdict.code;
      if (verdict.zero) begin
        present <= 1'b0;
        valid   <= 1'b0;
      end else begin
        present <= 1'b1;
        if (!verdict.hit) begin
          valid <= 1'b0;
        end else if (prev_hit && prev_code == verdict.code) begin
          ratio <= verdict.code;
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ref_ratio_detect.sv
module ref_ratio_detect
  import refdet_pkg::*;
#(
  parameter int WINDOW      = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int BAND_LO [NUM_BANDS] = '{270, 130, 30},
  parameter int BAND_HI [NUM_BANDS] = '{370, 190, 55}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_clk,
  output logic [1:0] ratio_code,
  output logic       ratio_valid,
  output logic       ref_present
);
  localparam int CW = $clog2(WINDOW + 1);

  logic          rise;
  logic          win_end;
  logic [CW-1:0] count;
  verdict_t      verdict;
  ratio_e        ratio;

  refdet_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .rise(rise)
  );

  refdet_window #(.WINDOW(WINDOW), .CW(CW)) u_win (
    .clk(clk), .rst(rst), .tick(rise), .win_end(win_end), .count(count)
  );

  refdet_classify #(.CW(CW), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)) u_cls (
    .count(count), .verdict(verdict)
  );

  refdet_decide u_dec (
    .clk(clk), .rst(rst), .win_end(win_end), .verdict(verdict),
    .ratio(ratio), .valid(ratio_valid), .present(ref_present)
  );

  assign ratio_code = ratio;
endmodule

// File: rtl/refdet_checker.sv
module refdet_checker #(
  parameter int WINDOW = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ratio_code,
  input logic       ratio_valid,
  input logic       ref_present
);
  localparam int PW = $clog2(WINDOW + 1);
  logic [PW-1:0] phase;

  // independent cycle tracker: window ends every WINDOW cycles after reset
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == PW'(WINDOW - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ratio_code == 2'd0 && !ratio_valid && !ref_present));

  assert_change_at_window_end_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ratio_code) || !$stable(ratio_valid) || !$stable(ref_present)) |-> phase == '0);

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    ratio_code != 2'd3);

  assert_valid_needs_ref_R9: assert property (@(posedge clk) disable iff (rst)
    ratio_valid |-> ref_present);

  assert_code_moves_on_commit_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_code) |-> ratio_valid);

  assert_loss_clears_valid_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_present) |-> (!ratio_valid && $stable(ratio_code)));
endmodule

bind ref_ratio_detect refdet_checker #(.WINDOW(WINDOW)) u_refdet_checker (
  .clk(clk), .rst(rst), .ratio_code(ratio_code),
  .ratio_valid(ratio_valid), .ref_present(ref_present)
);

// File: tb/ref_ratio_detect_test.sv
module ref_ratio_detect_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 1024;
  // reference half periods: counts per window ~41, ~160, ~320, ~102
  localparam int HALF_SLOW = 125;
  localparam int HALF_MID  = 32;
  localparam int HALF_FAST = 16;
  localparam int HALF_OOB  = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk = 1'b0;
  logic [1:0] ratio_code;
  logic       ratio_valid;
  logic       ref_present;

  logic ref_on = 1'b0;
  int   ref_half = HALF_SLOW;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;

  ref_ratio_detect #(.WINDOW(WIN)) uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid), .ref_present(ref_present)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always begin
    if (ref_on) begin
      #(ref_half) ref_clk = ~ref_clk;
    end else begin
      ref_clk = 1'b0;
      #(CLK_PERIOD / 2);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    ref_on = 1'b0;
    wait_cycles(5);
    chk("R1 code", ratio_code, 0);
    chk("R1 valid", ratio_valid, 0);
    chk("R1 present", ref_present, 0);
    rst = 1'b0;
    wait_cycles(1);
    chk("R1 code after release", ratio_code, 0);
    chk("R1 present after release", ref_present, 0);
  endtask

  // settle on a reference and check committed ratio (R3, R7, R8)
  task automatic t_lock(input int half, input int exp_code, input string req);
    ref_half = half;
    ref_on = 1'b1;
    wait_cycles(3 * WIN + WIN / 2);
    chk({req, " code"}, ratio_code, exp_code);
    chk({req, " valid"}, ratio_valid, 1);
    chk("R7 present", ref_present, 1);
  endtask

  task automatic t_out_of_band(input int held_code);
    ref_half = HALF_OOB;
    ref_on = 1'b1;
    wait_cycles(3 * WIN + WIN / 2);
    chk("R6 valid cleared", ratio_valid, 0);
    chk("R6 code held", ratio_code, held_code);
    chk("R6 present kept", ref_present, 1);
  endtask

  task automatic t_no_ref(input int held_code);
    ref_on = 1'b0;
    wait_cycles(2 * WIN + WIN / 2);
    chk("R5 present cleared", ref_present, 0);
    chk("R5 valid cleared", ratio_valid, 0);
    chk("R5 code held", ratio_code, held_code);
  endtask

  // one whole window of the fast reference between slow windows (R4)
  task automatic t_debounce();
    ref_half = HALF_SLOW;
    ref_on = 1'b1;
    @(posedge ref_present);           // edge E is a window end
    wait_cycles(2 * WIN + 5);         // just past E+2W
    chk("R8 slow committed code", ratio_code, 2);
    chk("R8 slow committed valid", ratio_valid, 1);
    ref_half = HALF_FAST;
    wait_cycles(WIN);                 // just past E+3W
    ref_half = HALF_SLOW;
    chk("R4 code after foreign window", ratio_code, 2);
    chk("R4 valid after foreign window", ratio_valid, 1);
    wait_cycles(WIN / 2);
    chk("R4 code mid window", ratio_code, 2);
    wait_cycles(WIN / 2 + 10);        // past E+4W
    chk("R4 code after return", ratio_code, 2);
    chk("R4 valid after return", ratio_valid, 1);
  endtask

  initial begin
    t_reset();
    t_lock(HALF_SLOW, 2, "R3 x128");
    t_lock(HALF_MID, 1, "R8 x32");
    t_lock(HALF_FAST, 0, "R3 x16");
    t_out_of_band(0);
    t_no_ref(0);
    t_lock(HALF_MID, 1, "R8 reacquire x32");
    t_no_ref(1);
    t_debounce();
    t_no_ref(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule